// File: doc/BRIEF.md
# Multicore Doorbell Message Router

This block delivers doorbell interrupts between the cores of a cluster. A core issues a *send* by presenting a 32-bit message word on the send channel. The router decodes the message's type code into one of two doorbell classes: normal or critical. It then marks that class pending in every addressed core. A core is addressed when its processor-ID input matches the message's tag, or in every case when the message's broadcast bit is set. A core issues a *clear* on the separate clear channel, naming itself and giving a message word. The router drops the pending bit of the decoded class in that one core. Message types that do not decode to a doorbell class are discarded without any effect.

Each core holds its pending state in a small state machine. The states are `PS_IDLE` (nothing pending), `PS_NORM` (normal doorbell pending), `PS_CRIT` (critical doorbell pending) and `PS_BOTH` (both pending). From any state, one update can take one of three transitions. RAISE adds the classes that a send sets. DROP removes the class that a clear names. HOLD keeps the state when neither applies. When RAISE and DROP target the same class in the same cycle, RAISE wins. The send and clear channels are separate, so one cycle can carry both kinds of operation. Each core has an interrupt-request line that is high while either of its classes is pending.

Top module: `doorbell_router`

## Requirements
- R1: After reset every pending bit and every interrupt-request line is 0.
- R2: The message type is held in bits [31:27]. Code 0 selects the normal doorbell, which is pending bit 2*c of core c. Code 1 selects the critical doorbell, which is pending bit 2*c+1 of core c.
- R3: A message with any type code from 2 to 31 changes nothing, whether it arrives on the send channel or the clear channel.
- R4: A send with bit 26 clear sets the decoded bit in every core whose 14-bit processor ID equals message bits [13:0]. If several cores share that ID, all of them receive it. No other core is touched.
- R5: A send with bit 26 set sets the decoded bit in all cores, regardless of the tag.
- R6: A clear drops only the decoded bit of the core named on `clr_core`. The other bit of that core and all bits of other cores are left unchanged.
- R7: Pending bits change at the first clock edge after the strobe and are unchanged before it. With no strobe they hold.
- R8: When a send and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: Each core's interrupt-request line equals the OR of that core's two pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_valid | input | 1 | Send operation strobe |
| snd_msg | input | 32 | Send message word (type, broadcast, tag) |
| clr_valid | input | 1 | Clear operation strobe |
| clr_core | input | CORE_W (2) | Index of the core issuing the clear |
| clr_msg | input | 32 | Clear message word (type field used) |
| pir_flat | input | NCORES*TAG_W (56) | Processor ID of each core, core c at [c*14 +: 14] |
| pend_flat | output | 2*NCORES (8) | Pending bits, core c at [2c+1:2c] = {critical, normal} |
| irq | output | NCORES (4) | Per-core interrupt-request line |

## Verification
The assertions check several behaviours on every cycle. Pending state holds when no strobe is present. Pending state also holds under sends and clears of undecoded types. Broadcast normal sends reach every core. A clear empties the named bit and leaves every other core alone. A set wins over a clear of the same bit in the same cycle. Each request line tracks its pending pair. Other behaviours can only be shown by the bench's scenarios, checked against its reference model. These are the reset value and tag matching against chosen and duplicated processor IDs. They also include the exact one-cycle latency, and the long random mixes of sends and clears where pending state builds up.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int MSG_W     = 32;
    localparam int TYPE_HI   = 31;
    localparam int TYPE_LO   = 27;
    localparam int TYPE_W    = TYPE_HI - TYPE_LO + 1;
    localparam int BCAST_BIT = 26;
    localparam int TAG_BITS  = 14;

    typedef enum logic [TYPE_W-1:0] {
        MT_NORMAL     = 5'd0,
        MT_CRITICAL   = 5'd1,
        MT_GUEST      = 5'd2,
        MT_GUEST_CRIT = 5'd3,
        MT_GUEST_MC   = 5'd4
    } msg_type_e;

    typedef struct packed {
        logic crit;
        logic norm;
    } db_class_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'b00,
        PS_NORM = 2'b01,
        PS_CRIT = 2'b10,
        PS_BOTH = 2'b11
    } pend_state_e;

endpackage

// File: rtl/db_msg_decode.sv
module db_msg_decode
    import db_pkg::*;
#(
    parameter int TAG_W = TAG_BITS
) (
    input  logic [MSG_W-1:0] msg,
    output db_class_t        cls,
    output logic             bcast,
    output logic [TAG_W-1:0] tag
);
    msg_type_e mtype;
    logic      unused_mid;

    assign mtype      = msg_type_e'(msg[TYPE_HI:TYPE_LO]);
    assign bcast      = msg[BCAST_BIT];
    assign tag        = msg[TAG_W-1:0];
    assign unused_mid = ^msg[BCAST_BIT-1:TAG_W];

    always_comb begin
        cls = '0;
        unique case (mtype)
            MT_NORMAL:   cls.norm = 1'b1;
            MT_CRITICAL: cls.crit = 1'b1;
            // guest kinds and unknown codes deliver nothing
            default:     cls = '0;
        endcase
    end

endmodule

// File: rtl/db_target_match.sv
module db_target_match #(
    parameter int NCORES = 4,
    parameter int TAG_W  = 14
) (
    input  logic [TAG_W-1:0]        tag,
    input  logic                    bcast,
    input  logic [NCORES*TAG_W-1:0] pir_flat,
    output logic [NCORES-1:0]       hit
);
    for (genvar i = 0; i < NCORES; i++) begin : g_cmp
        assign hit[i] = bcast || (pir_flat[i*TAG_W +: TAG_W] == tag);
    end
endmodule

// File: rtl/db_core_pend.sv
module db_core_pend
    import db_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  db_class_t set_cls,
    input  db_class_t clr_cls,
    output logic [1:0] pend,
    output logic      irq
);
    pend_state_e state, state_n;

    function automatic pend_state_e enc(input logic c, input logic n);
        return pend_state_e'({c, n});
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_n;
    end

    // RAISE ORs in set classes, DROP removes cleared ones; set beats clear
    always_comb begin
        state_n = state;
        unique case (state)
            PS_IDLE: state_n = enc(set_cls.crit, set_cls.norm);
            PS_NORM: state_n = enc(set_cls.crit, set_cls.norm | ~clr_cls.norm);
            PS_CRIT: state_n = enc(set_cls.crit | ~clr_cls.crit, set_cls.norm);
            PS_BOTH: state_n = enc(set_cls.crit | ~clr_cls.crit,
                                   set_cls.norm | ~clr_cls.norm);
            default: state_n = PS_IDLE;
        endcase
    end

    always_comb begin
        pend = 2'b00;
        irq  = 1'b0;
        unique case (state)
            PS_IDLE: begin pend = 2'b00; irq = 1'b0; end
            PS_NORM: begin pend = 2'b01; irq = 1'b1; end
            PS_CRIT: begin pend = 2'b10; irq = 1'b1; end
            PS_BOTH: begin pend = 2'b11; irq = 1'b1; end
            default: begin pend = 2'b00; irq = 1'b0; end
        endcase
    end
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
    import db_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int TAG_W  = TAG_BITS,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snd_valid,
    input  logic [MSG_W-1:0]        snd_msg,
    input  logic                    clr_valid,
    input  logic [CORE_W-1:0]       clr_core,
    input  logic [MSG_W-1:0]        clr_msg,
    input  logic [NCORES*TAG_W-1:0] pir_flat,
    output logic [2*NCORES-1:0]     pend_flat,
    output logic [NCORES-1:0]       irq
);
    db_class_t          snd_cls, clr_cls;
    logic               snd_bcast;
    logic [TAG_W-1:0]   snd_tag;
    logic               unused_clr_bcast;
    logic [TAG_W-1:0]   unused_clr_tag;
    logic [NCORES-1:0]  hit;

    db_msg_decode #(.TAG_W(TAG_W)) u_snd_dec (
        .msg(snd_msg), .cls(snd_cls), .bcast(snd_bcast), .tag(snd_tag)
    );

    db_msg_decode #(.TAG_W(TAG_W)) u_clr_dec (
        .msg(clr_msg), .cls(clr_cls), .bcast(unused_clr_bcast), .tag(unused_clr_tag)
    );

    db_target_match #(.NCORES(NCORES), .TAG_W(TAG_W)) u_match (
        .tag(snd_tag), .bcast(snd_bcast), .pir_flat(pir_flat), .hit(hit)
    );

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        db_class_t set_i, clr_i;
        assign set_i = (snd_valid && hit[i]) ? snd_cls : '0;
        assign clr_i = (clr_valid && clr_core == CORE_W'(i)) ? clr_cls : '0;

        db_core_pend u_pend (
            .clk(clk), .rst_n(rst_n),
            .set_cls(set_i), .clr_cls(clr_i),
            .pend(pend_flat[2*i +: 2]), .irq(irq[i])
        );
    end

endmodule

// File: rtl/db_router_chk.sv
module db_router_chk #(
    parameter int NCORES = 4,
    parameter int TAG_W  = 14,
    parameter int CORE_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    snd_valid,
    input logic [31:0]             snd_msg,
    input logic                    clr_valid,
    input logic [CORE_W-1:0]       clr_core,
    input logic [31:0]             clr_msg,
    input logic [NCORES*TAG_W-1:0] pir_flat,
    input logic [2*NCORES-1:0]     pend_flat,
    input logic [NCORES-1:0]       irq
);
    logic                snd_known, clr_known, clr_in_range;
    logic                bcast_norm, all_norm, same_bit_both;
    logic [2*NCORES-1:0] clr_bit_mask, clr_core_mask;
    logic [NCORES-1:0]   irq_expect;
    logic                unused_pir;

    assign unused_pir   = ^pir_flat;
    assign snd_known    = snd_msg[31:27] < 5'd2;
    assign clr_known    = clr_msg[31:27] < 5'd2;
    assign clr_in_range = 32'(clr_core) < NCORES;
    assign bcast_norm   = snd_valid && snd_msg[26] && snd_msg[31:27] == 5'd0;
    assign same_bit_both = snd_valid && snd_msg[26] && snd_known && clr_valid
                           && clr_known && clr_in_range
                           && snd_msg[31:27] == clr_msg[31:27];

    always_comb begin
        all_norm      = 1'b1;
        clr_bit_mask  = '0;
        clr_core_mask = '0;
        for (int i = 0; i < NCORES; i++) begin
            all_norm      = all_norm & pend_flat[2*i];
            irq_expect[i] = pend_flat[2*i] | pend_flat[2*i+1];
            if (32'(clr_core) == i) begin
                clr_core_mask[2*i +: 2] = 2'b11;
                if (clr_known) clr_bit_mask[2*i + 32'(clr_msg[27])] = 1'b1;
            end
        end
    end

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!snd_valid && !clr_valid) |=> $stable(pend_flat));

    // R3
    unknown_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!snd_valid || !snd_known) && (!clr_valid || !clr_known))
        |=> $stable(pend_flat));

    // R5
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_norm |=> all_norm);

    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !snd_valid && clr_in_range)
        |=> ((pend_flat & $past(clr_bit_mask)) == '0));

    // R6
    clr_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !snd_valid)
        |=> ((pend_flat & ~$past(clr_core_mask)) ==
             ($past(pend_flat) & ~$past(clr_core_mask))));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_bit_both |=> ((pend_flat & $past(clr_bit_mask)) == $past(clr_bit_mask)));

    // R9
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == irq_expect);

endmodule

bind doorbell_router db_router_chk #(
    .NCORES(NCORES), .TAG_W(TAG_W), .CORE_W(CORE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_msg(snd_msg),
    .clr_valid(clr_valid), .clr_core(clr_core), .clr_msg(clr_msg),
    .pir_flat(pir_flat), .pend_flat(pend_flat), .irq(irq)
);

// File: tb/doorbell_router_test.sv
module doorbell_router_test;
    localparam int NC = 4;
    localparam int TW = 14;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            snd_valid = 1'b0;
    logic [31:0]     snd_msg = '0;
    logic            clr_valid = 1'b0;
    logic [CW-1:0]   clr_core = '0;
    logic [31:0]     clr_msg = '0;
    logic [NC*TW-1:0] pir_flat;
    logic [2*NC-1:0] pend_flat;
    logic [NC-1:0]   irq;

    int checks = 0;
    int errors = 0;
    logic [2*NC-1:0] mdl = '0;

    always #5 clk = ~clk;

    doorbell_router #(.NCORES(NC), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_msg(snd_msg),
        .clr_valid(clr_valid), .clr_core(clr_core), .clr_msg(clr_msg),
        .pir_flat(pir_flat), .pend_flat(pend_flat), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [4:0] t, input logic b,
                                       input logic [13:0] tg);
        return {t, b, 12'h000, tg};
    endfunction

    function automatic logic [2*NC-1:0] model_next(
        input logic [2*NC-1:0] cur, input logic sv, input logic [31:0] sm,
        input logic cv, input logic [CW-1:0] cc, input logic [31:0] cm,
        input logic [NC*TW-1:0] pir);
        logic [2*NC-1:0] n;
        n = cur;
        if (cv && cm[31:27] < 5'd2) n[2*int'(cc) + int'(cm[27])] = 1'b0;
        if (sv && sm[31:27] < 5'd2)
            for (int i = 0; i < NC; i++)
                if (sm[26] || pir[i*TW +: TW] == sm[13:0])
                    n[2*i + int'(sm[27])] = 1'b1;
        return n;
    endfunction

    function automatic logic [NC-1:0] irq_of(input logic [2*NC-1:0] p);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = p[2*i] | p[2*i+1];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the update
    task automatic op(input logic sv, input logic [31:0] sm, input logic cv,
                      input logic [CW-1:0] cc, input logic [31:0] cm);
        logic [2*NC-1:0] nxt;
        snd_valid = sv; snd_msg = sm; clr_valid = cv; clr_core = cc; clr_msg = cm;
        nxt = model_next(mdl, sv, sm, cv, cc, cm, pir_flat);
        @(posedge clk);
        @(negedge clk);
        snd_valid = 1'b0; clr_valid = 1'b0;
        mdl = nxt;
    endtask

    task automatic both(input string tag);
        chk(tag, 32'(pend_flat), 32'(mdl));
        chk("R9", 32'(irq), 32'(irq_of(mdl)));
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
    end

    initial begin
        for (int i = 0; i < NC; i++) pir_flat[i*TW +: TW] = 14'h0A0 + 14'(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 32'(pend_flat), 32'h0);
        chk("R1", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: normal doorbell to core 1 by tag
        op(1, mk(5'd0, 0, 14'h0A1), 0, 0, 0);
        both("R4");
        chk("R2", 32'(pend_flat), 32'h04);

        // R7: no change before the edge, change after
        snd_valid = 1; snd_msg = mk(5'd1, 1, 14'h3FFF);
        #1 chk("R7", 32'(pend_flat), 32'h04);
        op(1, mk(5'd1, 1, 14'h3FFF), 0, 0, 0);
        // R5 broadcast critical
        both("R5");
        chk("R5", 32'(pend_flat), 32'hAE);
        repeat (2) @(negedge clk);
        chk("R7", 32'(pend_flat), 32'hAE);

        // R6 clears
        op(0, 0, 1, 2'd1, mk(5'd0, 0, 0));
        both("R6");
        op(0, 0, 1, 2'd0, mk(5'd1, 0, 0));
        both("R6");
        chk("R6", 32'(pend_flat), 32'hA8);

        // R3 undecoded kinds do nothing
        op(1, mk(5'd3, 1, 14'h0A2), 1, 2'd2, mk(5'd4, 0, 0));
        both("R3");
        op(1, mk(5'd2, 1, 14'h0), 1, 2'd3, mk(5'd31, 0, 0));
        both("R3");

        // R8 set beats clear on the same bit
        op(1, mk(5'd1, 0, 14'h0A2), 1, 2'd2, mk(5'd1, 0, 0));
        both("R8");
        chk("R8", 32'(pend_flat[5]), 32'h1);

        // R4 duplicate IDs: cores 2 and 3 share one
        pir_flat[3*TW +: TW] = 14'h0A2;
        op(1, mk(5'd0, 0, 14'h0A2), 0, 0, 0);
        both("R4");
        op(1, mk(5'd0, 0, 14'h1234), 0, 0, 0);
        both("R4");

        // random mix
        void'($urandom(32'd2024));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            logic [4:0]  t1, t2;
            logic [13:0] tg;
            r  = $urandom;
            t1 = (r[2:0] < 3'd6) ? {4'b0, r[3]} : 5'(2 + (r[8:4] % 30));
            t2 = (r[11:9] < 3'd6) ? {4'b0, r[12]} : 5'(2 + (r[17:13] % 30));
            tg = r[18] ? 14'(r[31:19]) : pir_flat[int'(r[20:19])*TW +: TW];
            if (k % 97 == 0)
                for (int i = 0; i < NC; i++)
                    pir_flat[i*TW +: TW] = 14'h0A0 + 14'($urandom % 3);
            op(r[21], mk(t1, r[23:22] == 2'b00, tg), r[24], CW'(r[26:25]), mk(t2, 0, 0));
            both("R4");
        end
        summary();
    end
endmodule